// File: doc/BRIEF.md
# Crypto Engine Memory-Fetch Sequencer

This block reads message data straight out of memory on behalf of a hash or block-cipher core. Software programs a word-aligned start address, then writes a control word that carries an enable bit and a block count. The sequencer walks through consecutive 32-bit words on a request/grant/response memory port and hands each word to the crypto core over a valid/ready stream. It holds at most one read in flight, and it issues the next read only after the core has taken the previous word.

The block size follows the mode sampled at start. A hash block is 16 words. A cipher block is 4 words, and the first cipher block can be lengthened by a programmable number of key/IV words placed ahead of the data. The remaining-block count stays readable while the transfer runs and drops by one as each block completes. A hash job raises one completion pulse at the end. A cipher job raises a pulse per block.

A bus error, or a misaligned start address, sets a sticky error flag. A bus error stops the job with the count left on the failing block. Writing the enable bit low aborts a job that is running.

Top module: `cfs_fetch_seq`

## Requirements
- R1: After reset `ctl_rdata` reads 0, and `mem_req`, `out_valid`, `err_flag`, `irq_digest` and `irq_block` are low.
- R2: A control write with bit 0 set and a nonzero count in bits 26:16, made while idle with an aligned address, starts reads at the programmed address. Each later read is at the previous address plus 4.
- R3: A start with a count of 0 issues no memory read, leaves the sequencer idle and sets no error.
- R4: With `mode_aes` low a block is 16 words. With `mode_aes` high a block is 4 words, and `key_words` extra words come ahead of the first block only.
- R5: Bits 26:16 of `ctl_rdata` drop by one in the cycle after the last word of a block is accepted on the stream. They change by no other amount unless software writes them while idle, and they end at 0.
- R6: In hash mode `irq_digest` pulses for one cycle, once per job, together with the count reaching 0. In cipher mode `irq_block` pulses once per block. The two never fire in the same mode.
- R7: At most one read is outstanding. No read is requested while a word waits on the stream. `out_data` holds steady while `out_valid` is high and `out_ready` is low.
- R8: A response with `mem_rerr` high stops the job with no further reads. The count keeps the number of the failing block, and `err_flag` stays high until `err_clr` is pulsed.
- R9: A start while the programmed address has bits 1:0 nonzero issues no read and sets `err_flag`.
- R10: A control write with bit 0 clear during a job drops `mem_req` and `out_valid` from the next cycle on, and no further reads follow.
- R11: Words appear on `out_data` in address order, carrying exactly the value memory returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word: bit 0 enable, bits 26:16 block count |
| ctl_rdata | output | 32 | Control readback with live block count |
| addr_we | input | 1 | Start address write strobe (taken while idle) |
| addr_wdata | input | ADDR_W | Start byte address |
| mode_aes | input | 1 | 0 = hash blocks, 1 = cipher blocks; sampled at start |
| key_words | input | PRE_W | Extra words ahead of the first cipher block; sampled at start |
| err_clr | input | 1 | Clears the error flag |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DATA_W | Read response data |
| mem_rerr | input | 1 | Read response is a bus error |
| out_valid | output | 1 | Stream word valid |
| out_data | output | DATA_W | Stream word |
| out_ready | input | 1 | Crypto core accepts the word |
| irq_digest | output | 1 | Hash job completion pulse |
| irq_block | output | 1 | Cipher per-block pulse |
| err_flag | output | 1 | Sticky error, also the error interrupt |

## Verification
Each result has a fixed latency. The first request appears one cycle after the control write edge. A response moves to `out_valid` one cycle after `mem_rvalid`. The count step and the interrupt pulse land one cycle after the accepting handshake. An error sets the flag one cycle after the failing response. The bench's memory and sink models act on falling edges. They record each handshake in the half-cycle before the edge that consumes it and read the count on the next falling edge. Interrupt pulses are tallied on every falling edge, so each pulse is counted exactly once. Absence checks (no request after a zero count, an error or an abort) watch the port over a window of 20 cycles.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    localparam int HASH_BLK_WORDS = 16;
    localparam int AES_BLK_WORDS  = 4;
    localparam int CNT_W          = 11;
    localparam int CNT_LSB        = 16;
    localparam int EN_BIT         = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_PUSH = 2'd3
    } seq_st_e;

    typedef enum logic {
        MODE_HASH = 1'b0,
        MODE_AES  = 1'b1
    } crypt_mode_e;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } ctl_fields_t;

    function automatic int unsigned blk_words(crypt_mode_e m);
        return (m == MODE_AES) ? AES_BLK_WORDS : HASH_BLK_WORDS;
    endfunction

    function automatic logic [31:0] pack_ctl(ctl_fields_t f);
        logic [31:0] w;
        w = '0;
        w[EN_BIT] = f.en;
        w[CNT_LSB +: CNT_W] = f.cnt;
        return w;
    endfunction
endpackage

// File: rtl/cfs_addr_gen.sv
module cfs_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              misaligned
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + WORD_BYTES;
        end
    end

    assign misaligned = |addr[1:0];
endmodule

// File: rtl/cfs_blk_track.sv
module cfs_blk_track
    import cfs_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             start,
    input  crypt_mode_e      mode_in,
    input  logic [PRE_W-1:0] key_words,
    input  logic             word_done,
    output logic [CNT_W-1:0] cnt,
    output crypt_mode_e      mode_q,
    output logic             last_word,
    output logic             last_blk,
    output logic             blk_done
);
    localparam int WRD_W = $clog2(HASH_BLK_WORDS + (1 << PRE_W)) + 1;

    logic [WRD_W-1:0] wrem;
    logic [WRD_W-1:0] first_len;

    assign first_len = WRD_W'(blk_words(mode_in))
                     + ((mode_in == MODE_AES) ? WRD_W'(key_words) : '0);

    assign last_word = (wrem == WRD_W'(1));
    assign last_blk  = (cnt == CNT_W'(1));
    assign blk_done  = word_done && last_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            wrem   <= '0;
            mode_q <= MODE_HASH;
        end else begin
            if (cnt_load) begin
                cnt <= cnt_val;
            end else if (blk_done) begin
                cnt <= cnt - CNT_W'(1);
            end
            if (start) begin
                mode_q <= mode_in;
                wrem   <= first_len;
            end else if (word_done) begin
                wrem <= last_word ? WRD_W'(blk_words(mode_q)) : wrem - WRD_W'(1);
            end
        end
    end
endmodule

// File: rtl/cfs_seq_fsm.sv
module cfs_seq_fsm
    import cfs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    abort,
    input  logic    gnt,
    input  logic    rvalid,
    input  logic    rerr,
    input  logic    ready,
    input  logic    last_word,
    input  logic    last_blk,
    output seq_st_e state,
    output logic    word_done,
    output logic    bus_err
);
    seq_st_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (start)  nxt = ST_REQ;
            ST_REQ:  if (gnt)    nxt = ST_WAIT;
            ST_WAIT: if (rvalid) nxt = rerr ? ST_IDLE : ST_PUSH;
            ST_PUSH: if (ready)  nxt = (last_word && last_blk) ? ST_IDLE : ST_REQ;
            default: nxt = ST_IDLE;
        endcase
        if (abort) nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign word_done = (state == ST_PUSH) && ready;
    assign bus_err   = (state == ST_WAIT) && rvalid && rerr && !abort;
endmodule

// File: rtl/cfs_fetch_seq.sv
module cfs_fetch_seq
    import cfs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              mode_aes,
    input  logic [PRE_W-1:0]  key_words,
    input  logic              err_clr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              irq_digest,
    output logic              irq_block,
    output logic              err_flag
);
    seq_st_e          state;
    ctl_fields_t      wr_f;
    logic             en_q;
    logic             idle;
    logic             start_req, start, abort, misaligned;
    logic             word_done, bus_err;
    logic             last_word, last_blk, blk_done;
    logic [CNT_W-1:0] cnt;
    crypt_mode_e      mode_q;
    logic [DATA_W-1:0] data_q;
    logic             unused_ctl_bits;

    assign wr_f.en  = ctl_wdata[EN_BIT];
    assign wr_f.cnt = ctl_wdata[CNT_LSB +: CNT_W];
    assign unused_ctl_bits = ^{ctl_wdata[31:CNT_LSB+CNT_W], ctl_wdata[CNT_LSB-1:EN_BIT+1]};

    assign idle      = (state == ST_IDLE);
    assign start_req = ctl_we && wr_f.en && idle && (wr_f.cnt != '0);
    assign start     = start_req && !misaligned;
    assign abort     = ctl_we && !wr_f.en && !idle;

    cfs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (addr_we && idle),
        .load_val   (addr_wdata),
        .step       (mem_req && mem_gnt),
        .addr       (mem_addr),
        .misaligned (misaligned)
    );

    cfs_blk_track #(.PRE_W(PRE_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .cnt_load  (ctl_we && idle),
        .cnt_val   (wr_f.cnt),
        .start     (start),
        .mode_in   (crypt_mode_e'(mode_aes)),
        .key_words (key_words),
        .word_done (word_done),
        .cnt       (cnt),
        .mode_q    (mode_q),
        .last_word (last_word),
        .last_blk  (last_blk),
        .blk_done  (blk_done)
    );

    cfs_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .abort     (abort),
        .gnt       (mem_gnt),
        .rvalid    (mem_rvalid),
        .rerr      (mem_rerr),
        .ready     (out_ready),
        .last_word (last_word),
        .last_blk  (last_blk),
        .state     (state),
        .word_done (word_done),
        .bus_err   (bus_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            err_flag   <= 1'b0;
            data_q     <= '0;
            irq_digest <= 1'b0;
            irq_block  <= 1'b0;
        end else begin
            if (ctl_we) en_q <= wr_f.en;
            if (bus_err || (start_req && misaligned)) err_flag <= 1'b1;
            else if (err_clr)                         err_flag <= 1'b0;
            if (state == ST_WAIT && mem_rvalid && !mem_rerr) data_q <= mem_rdata;
            irq_block  <= blk_done && (mode_q == MODE_AES);
            irq_digest <= blk_done && last_blk && (mode_q == MODE_HASH);
        end
    end

    assign ctl_rdata = pack_ctl('{en: en_q, cnt: cnt});
    assign mem_req   = (state == ST_REQ);
    assign out_valid = (state == ST_PUSH);
    assign out_data  = data_q;
endmodule

// File: rtl/cfs_fetch_seq_chk.sv
module cfs_fetch_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_we,
    input logic [31:0]       ctl_wdata,
    input logic [31:0]       ctl_rdata,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              mem_rerr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ready,
    input logic              irq_digest,
    input logic              irq_block,
    input logic              err_flag
);
    logic [10:0] cnt_rd;
    logic        pend;

    assign cnt_rd = ctl_rdata[26:16];

    always_ff @(posedge clk) begin
        if (rst)                     pend <= 1'b0;
        else if (mem_req && mem_gnt) pend <= 1'b1;
        else if (mem_rvalid)         pend <= 1'b0;
    end

    p_one_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_gnt |=> !mem_req);

    p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !(ctl_we && !ctl_wdata[0]) |=> out_valid && $stable(out_data));

    p_no_req_with_word_r7: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && mem_req));

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> (cnt_rd == $past(cnt_rd)) || (cnt_rd == $past(cnt_rd) - 11'd1));

    p_zero_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd == 11'd0) |-> !mem_req && !out_valid);

    p_irq_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(irq_digest && irq_block));

    p_err_stops_r8: assert property (@(posedge clk) disable iff (rst)
        pend && mem_rvalid && mem_rerr && !ctl_we |=> err_flag && !mem_req && !out_valid);

    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_we && !ctl_wdata[0] |=> !mem_req && !out_valid);
endmodule

bind cfs_fetch_seq cfs_fetch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rerr   (mem_rerr),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .irq_digest (irq_digest),
    .irq_block  (irq_block),
    .err_flag   (err_flag)
);

// File: tb/cfs_fetch_seq_test.sv
module cfs_fetch_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [31:0] ctl_wdata;
    logic [31:0] ctl_rdata;
    logic        addr_we;
    logic [31:0] addr_wdata;
    logic        mode_aes;
    logic [3:0]  key_words;
    logic        err_clr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        mem_rerr;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready;
    logic        irq_digest;
    logic        irq_block;
    logic        err_flag;

    cfs_fetch_seq uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .mode_aes(mode_aes), .key_words(key_words),
        .err_clr(err_clr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .irq_digest(irq_digest), .irq_block(irq_block), .err_flag(err_flag)
    );

    initial forever #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int nwords = 0;
    int nreq = 0;
    int irq_blk_n = 0;
    int irq_dig_n = 0;
    logic [31:0] got_data [0:127];
    logic [10:0] got_cnt  [0:127];
    logic [31:0] req_log  [0:127];
    logic        hs_prev = 1'b0;
    logic        rsp_pend = 1'b0;
    logic        rsp_err = 1'b0;
    logic [31:0] rsp_addr = '0;
    logic        gnt_slow = 1'b0;
    logic        rdy_slow = 1'b0;
    logic        err_armed = 1'b0;
    logic [31:0] err_addr = '0;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // memory, sink and interrupt monitor, all acting on falling edges
    initial begin
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0; mem_rerr = 0; out_ready = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (hs_prev) begin
                got_cnt[nwords-1] = ctl_rdata[26:16];
                hs_prev = 1'b0;
            end
            if (irq_block)  irq_blk_n++;
            if (irq_digest) irq_dig_n++;
            mem_rvalid = rsp_pend;
            mem_rerr   = rsp_pend && rsp_err;
            mem_rdata  = rsp_pend ? mem_word(rsp_addr) : 32'h0;
            rsp_pend   = 1'b0;
            mem_gnt    = mem_req && (!gnt_slow || cyc[0]);
            if (mem_gnt) begin
                req_log[nreq] = mem_addr;
                nreq++;
                rsp_pend = 1'b1;
                rsp_addr = mem_addr;
                rsp_err  = err_armed && (mem_addr == err_addr);
            end
            out_ready = !rdy_slow || (cyc % 3 != 0);
            if (out_valid && out_ready) begin
                got_data[nwords] = out_data;
                nwords++;
                hs_prev = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic clear_logs();
        @(negedge clk);
        nwords = 0; nreq = 0; irq_blk_n = 0; irq_dig_n = 0;
    endtask

    task automatic launch(logic [31:0] a, int cnt, logic aes, logic [3:0] kw);
        clear_logs();
        addr_we = 1; addr_wdata = a; mode_aes = aes; key_words = kw;
        @(negedge clk);
        addr_we = 0;
        ctl_we = 1; ctl_wdata = {5'b0, 11'(cnt), 15'b0, 1'b1};
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic wait_words(int n);
        for (int i = 0; i < 3000 && nwords < n; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "ctl_rdata", ctl_rdata, 32'h0);
        chk("R1", "mem_req/out_valid", {mem_req, out_valid}, 2'b00);
        chk("R1", "err/irqs", {err_flag, irq_digest, irq_block}, 3'b000);
    endtask

    task automatic t_hash_two();
        int bad_d = 0;
        int bad_a = 0;
        launch(32'h100, 2, 1'b0, 4'd3);
        wait_words(32);
        chk("R4", "hash word count", nwords, 32);
        for (int i = 0; i < 32; i++) begin
            if (got_data[i] !== mem_word(32'h100 + 4*i)) bad_d++;
            if (req_log[i] !== 32'h100 + 4*i) bad_a++;
        end
        chk("R11", "hash data mismatches", bad_d, 0);
        chk("R2", "hash address mismatches", bad_a, 0);
        chk("R5", "count before block end", got_cnt[14], 11'd2);
        chk("R5", "count after block 1", got_cnt[15], 11'd1);
        chk("R5", "count at end", got_cnt[31], 11'd0);
        chk("R6", "digest pulses", irq_dig_n, 1);
        chk("R6", "block pulses in hash", irq_blk_n, 0);
    endtask

    task automatic t_aes_three();
        int bad_d = 0;
        launch(32'h2000, 3, 1'b1, 4'd2);
        wait_words(14);
        chk("R4", "aes word count with key words", nwords, 14);
        for (int i = 0; i < 14; i++)
            if (got_data[i] !== mem_word(32'h2000 + 4*i)) bad_d++;
        chk("R11", "aes data mismatches", bad_d, 0);
        chk("R5", "aes count after extended first block", got_cnt[5], 11'd2);
        chk("R5", "aes count mid second block", got_cnt[8], 11'd2);
        chk("R5", "aes count after block 2", got_cnt[9], 11'd1);
        chk("R5", "aes count end", got_cnt[13], 11'd0);
        chk("R6", "aes block pulses", irq_blk_n, 3);
        chk("R6", "digest pulses in aes", irq_dig_n, 0);
    endtask

    task automatic t_backpressure();
        int bad_d = 0;
        gnt_slow = 1; rdy_slow = 1;
        launch(32'h3000, 1, 1'b0, 4'd0);
        wait_words(16);
        for (int i = 0; i < 16; i++)
            if (got_data[i] !== mem_word(32'h3000 + 4*i)) bad_d++;
        chk("R7", "stalled data mismatches", bad_d, 0);
        chk("R7", "stalled read count", nreq, 16);
        chk("R6", "stalled digest pulses", irq_dig_n, 1);
        gnt_slow = 0; rdy_slow = 0;
    endtask

    task automatic t_zero();
        launch(32'h500, 0, 1'b0, 4'd0);
        repeat (20) @(negedge clk);
        chk("R3", "reads on zero count", nreq, 0);
        chk("R3", "words on zero count", nwords, 0);
        chk("R3", "error on zero count", err_flag, 1'b0);
    endtask

    task automatic t_misalign();
        launch(32'h102, 2, 1'b0, 4'd0);
        repeat (20) @(negedge clk);
        chk("R9", "reads on misaligned start", nreq, 0);
        chk("R9", "error on misaligned start", err_flag, 1'b1);
        err_clr = 1; @(negedge clk); err_clr = 0;
        @(negedge clk);
        chk("R8", "error cleared", err_flag, 1'b0);
    endtask

    task automatic t_bus_error();
        int nreq_then;
        err_armed = 1; err_addr = 32'h400 + 4*19;
        launch(32'h400, 3, 1'b0, 4'd0);
        repeat (150) @(negedge clk);
        chk("R8", "words before error", nwords, 19);
        chk("R8", "reads up to failing one", nreq, 20);
        chk("R8", "count holds failing block", ctl_rdata[26:16], 11'd2);
        chk("R8", "error flag set", err_flag, 1'b1);
        chk("R6", "no digest after error", irq_dig_n, 0);
        nreq_then = nreq;
        repeat (20) @(negedge clk);
        chk("R8", "no reads after error", nreq, nreq_then);
        chk("R8", "error flag sticky", err_flag, 1'b1);
        err_armed = 0;
        err_clr = 1; @(negedge clk); err_clr = 0;
        @(negedge clk);
        chk("R8", "error flag cleared", err_flag, 1'b0);
    endtask

    task automatic t_abort();
        int nreq_then;
        launch(32'h800, 2, 1'b0, 4'd0);
        for (int i = 0; i < 500 && nwords < 5; i++) @(negedge clk);
        ctl_we = 1; ctl_wdata = 32'h0;
        @(negedge clk);
        ctl_we = 0;
        chk("R10", "req/valid after abort", {mem_req, out_valid}, 2'b00);
        chk("R10", "enable reads 0", ctl_rdata[0], 1'b0);
        repeat (2) @(negedge clk);
        nreq_then = nreq;
        repeat (20) @(negedge clk);
        chk("R10", "no reads after abort", nreq, nreq_then);
    endtask

    initial begin
        rst = 1; ctl_we = 0; ctl_wdata = 0; addr_we = 0; addr_wdata = 0;
        mode_aes = 0; key_words = 0; err_clr = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_hash_two();
        t_aes_three();
        t_backpressure();
        t_zero();
        t_misalign();
        t_bus_error();
        t_abort();
        finish_run();
    end
endmodule